// File: doc/BRIEF.md
# Fractional-Rate Time Base Counter

This block keeps a free-running count that advances at a constant nominal rate, whatever the frequency of the reference clock that drives it. On every reference clock edge it adds a programmable fraction to the count. The fraction is a numerator over a denominator. An accumulator carries the remainder, so the long-run count rate is exactly the programmed ratio of the clock rate and no rounding error builds up. Software picks the ratio that matches the reference frequency so that the output rate stays fixed. For example, 4/25 of 38.4 MHz and 8/25 of 19.2 MHz both give 6.144 MHz.

The ratio sits in two 32-bit registers on a simple write/read port. The numerator is at byte offset 0x10 and the denominator is at 0x14. Each value sits in the low 12 bits of its register. The upper 20 bits of both registers are fixed by parameters, and writes never alter them. A write to the denominator restarts the accumulator, so a ratio change starts from a known phase. A write to the numerator takes effect from the following clock. The count never jumps by more than one and never repeats a value.

Top module: `ratio_tick_counter`

## Requirements
- R1: During and right after reset, the count is 0, the numerator field holds 4 and the denominator field holds 25. Both registers read back with their upper 20 bits equal to the parameter values NUM_HI_RST and DEN_HI_RST.
- R2: When the numerator is below the effective denominator, each clock adds the numerator to the accumulator. When the sum reaches the denominator, the count rises by one and the denominator is subtracted. Starting from an empty accumulator, N clocks therefore add floor(N*num/den) to the count.
- R3: From one clock to the next, the count either stays the same or rises by exactly one.
- R4: A write to offset 0x10 sets the numerator field and a write to 0x14 sets the denominator field, each from wr_data[11:0]. Bits [31:12] of the written data are ignored, and the register bits [31:12] keep their parameter values.
- R5: A write to any other offset changes neither register.
- R6: A numerator write is used by the accumulator from the clock after the write. The clock of the write still uses the old value.
- R7: On the clock of a denominator write, the accumulator is cleared and the count does not advance.
- R8: A denominator field of 0 acts as a denominator of 1.
- R9: When the numerator is greater than or equal to the effective denominator, the count rises by one on every clock and the accumulator stays at 0.
- R10: The count wraps from its all-ones value to 0 with no other effect.
- R11: rd_data returns the numerator register for rd_addr 0x10, the denominator register for 0x14, and 0 for any other address, all in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the write |
| wr_data | input | 32 | Write data; only bits [11:0] are used |
| rd_addr | input | 8 | Byte offset of the read |
| rd_data | output | 32 | Read data, combinational |
| count_o | output | COUNT_W (64) | Free-running count |

## Verification
The counting function is driven with every listed reference ratio, and also with a zero numerator, a zero denominator, ratios at or above one, and the widest 12-bit ratio. Each case runs for a clock count that leaves a fractional remainder, so a count that rounds up, drops the remainder or adds twice per clock gives a different total. Separate sequences write the numerator mid-run and write the denominator mid-run. The expected totals there differ depending on whether the new value is used at the write clock or one clock later, and on whether the accumulator is restarted. A wrap run checks that the count rolls from all-ones to zero.

// File: rtl/rtk_pkg.sv
package rtk_pkg;
    localparam int unsigned FIELD_W = 12;
    localparam int unsigned REG_W   = 32;
    localparam int unsigned HI_W    = REG_W - FIELD_W;
    localparam int unsigned ADDR_W  = 8;
    localparam int unsigned ACC_W   = FIELD_W + 1;

    localparam logic [ADDR_W-1:0]  NUM_OFF = 8'h10;
    localparam logic [ADDR_W-1:0]  DEN_OFF = 8'h14;
    localparam logic [FIELD_W-1:0] NUM_RST = 12'd4;
    localparam logic [FIELD_W-1:0] DEN_RST = 12'd25;

    typedef logic [FIELD_W-1:0] field_t;
    typedef logic [ACC_W-1:0]   acc_t;

    typedef struct packed {
        field_t num;
        field_t den;
    } ratio_t;
endpackage

// File: rtl/rtk_ratio_regs.sv
module rtk_ratio_regs
    import rtk_pkg::*;
#(
    parameter logic [HI_W-1:0] NUM_HI_RST = '0,
    parameter logic [HI_W-1:0] DEN_HI_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    output field_t            num_o,
    output field_t            den_o,
    output logic              den_wr_o
);
    ratio_t st_d, st_q;
    logic   den_wr_d;
    logic   unused_wr_hi;

    // upper data bits carry no meaning for either register
    assign unused_wr_hi = ^wr_data[REG_W-1:FIELD_W];

    always_comb begin
        st_d     = st_q;
        den_wr_d = 1'b0;
        if (wr_en) begin
            case (wr_addr)
                NUM_OFF: st_d.num = wr_data[FIELD_W-1:0];
                DEN_OFF: begin
                    st_d.den = wr_data[FIELD_W-1:0];
                    den_wr_d = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{num: NUM_RST, den: DEN_RST};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_addr)
            NUM_OFF: rd_data = {NUM_HI_RST, st_q.num};
            DEN_OFF: rd_data = {DEN_HI_RST, st_q.den};
            default: rd_data = '0;
        endcase
    end

    assign num_o    = st_q.num;
    assign den_o    = st_q.den;
    assign den_wr_o = den_wr_d;
endmodule

// File: rtl/rtk_frac_accum.sv
module rtk_frac_accum
    import rtk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  field_t num_i,
    input  field_t den_i,
    input  logic   restart_i,
    output logic   step_o,
    output acc_t   acc_o,
    output acc_t   den_eff_o
);
    acc_t acc_d, acc_q;
    acc_t den_eff;
    acc_t sum;
    acc_t num_x;
    logic step_d;

    always_comb begin
        den_eff = (den_i == '0) ? acc_t'(1) : {1'b0, den_i};
        num_x   = {1'b0, num_i};
        sum     = acc_q + num_x;
        acc_d   = sum;
        step_d  = 1'b0;
        if (restart_i) begin
            acc_d  = '0;
            step_d = 1'b0;
        end else if (num_x >= den_eff) begin
            acc_d  = '0;
            step_d = 1'b1;
        end else if (sum >= den_eff) begin
            acc_d  = sum - den_eff;
            step_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign step_o    = step_d;
    assign acc_o     = acc_q;
    assign den_eff_o = den_eff;
endmodule

// File: rtl/rtk_count.sv
module rtk_count #(
    parameter int unsigned COUNT_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_i,
    output logic [COUNT_W-1:0] count_o
);
    logic [COUNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (step_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/ratio_tick_counter.sv
module ratio_tick_counter
    import rtk_pkg::*;
#(
    parameter int unsigned      COUNT_W    = 64,
    parameter logic [HI_W-1:0] NUM_HI_RST = '0,
    parameter logic [HI_W-1:0] DEN_HI_RST = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_addr,
    input  logic [31:0]        wr_data,
    input  logic [7:0]         rd_addr,
    output logic [31:0]        rd_data,
    output logic [COUNT_W-1:0] count_o
);
    field_t ratio_num;
    field_t ratio_den;
    logic   den_wr;
    logic   step;
    acc_t   acc_val;
    acc_t   den_eff;

    rtk_ratio_regs #(
        .NUM_HI_RST(NUM_HI_RST),
        .DEN_HI_RST(DEN_HI_RST)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .num_o   (ratio_num),
        .den_o   (ratio_den),
        .den_wr_o(den_wr)
    );

    rtk_frac_accum u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .num_i    (ratio_num),
        .den_i    (ratio_den),
        .restart_i(den_wr),
        .step_o   (step),
        .acc_o    (acc_val),
        .den_eff_o(den_eff)
    );

    rtk_count #(
        .COUNT_W(COUNT_W)
    ) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (step),
        .count_o(count_o)
    );
endmodule

// File: rtl/ratio_tick_counter_chk.sv
module ratio_tick_counter_chk
    import rtk_pkg::*;
#(
    parameter int unsigned      COUNT_W    = 64,
    parameter logic [HI_W-1:0] NUM_HI_RST = '0,
    parameter logic [HI_W-1:0] DEN_HI_RST = '0
) (
    input logic               clk,
    input logic               rst_n,
    input logic [COUNT_W-1:0] count_o,
    input field_t             ratio_num,
    input field_t             ratio_den,
    input logic               den_wr,
    input acc_t               acc_val,
    input acc_t               den_eff,
    input logic [7:0]         rd_addr,
    input logic [31:0]        rd_data
);
    // R3: count holds or rises by one
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

    // R2: remainder always below the effective denominator
    a_r2_acc_below_den: assert property (@(posedge clk) disable iff (!rst_n)
        acc_val < den_eff);

    // R7: denominator write restarts the remainder without counting
    a_r7_den_restart: assert property (@(posedge clk) disable iff (!rst_n)
        den_wr |=> (acc_val == '0) && (count_o == $past(count_o)));

    // R9: ratio of one or more counts every clock
    a_r9_full_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_wr && ({1'b0, ratio_num} >= den_eff)) |=> (count_o == $past(count_o) + 1'b1));

    // R8: zero denominator behaves as one
    a_r8_zero_den: assert property (@(posedge clk) disable iff (!rst_n)
        (!den_wr && ratio_den == '0 && ratio_num != '0) |=> (count_o == $past(count_o) + 1'b1));

    // R4: upper register bits fixed
    a_r4_num_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == NUM_OFF) |-> (rd_data[31:FIELD_W] == NUM_HI_RST));
    a_r4_den_hi_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == DEN_OFF) |-> (rd_data[31:FIELD_W] == DEN_HI_RST));
endmodule

bind ratio_tick_counter ratio_tick_counter_chk #(
    .COUNT_W   (COUNT_W),
    .NUM_HI_RST(NUM_HI_RST),
    .DEN_HI_RST(DEN_HI_RST)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .count_o  (count_o),
    .ratio_num(ratio_num),
    .ratio_den(ratio_den),
    .den_wr   (den_wr),
    .acc_val  (acc_val),
    .den_eff  (den_eff),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data)
);

// File: tb/test_ratio_tick_counter.sv
`timescale 1ns/1ps
module test_ratio_tick_counter;
    localparam int unsigned CW = 12;
    localparam logic [19:0] NHI = 20'hC3A5F;
    localparam logic [19:0] DHI = 20'h5A01E;
    localparam logic [7:0]  A_NUM = 8'h10;
    localparam logic [7:0]  A_DEN = 8'h14;

    typedef struct packed {
        logic [11:0] num;
        logic [11:0] den;
        logic [15:0] n;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [0:NV-1] = '{
        '{num: 12'd4,    den: 12'd25,   n: 16'd100, exp: 16'd16},  // R2 38.4 MHz ratio
        '{num: 12'd8,    den: 12'd25,   n: 16'd100, exp: 16'd32},  // R2
        '{num: 12'd64,   den: 12'd125,  n: 16'd250, exp: 16'd128}, // R2
        '{num: 12'd768,  den: 12'd1625, n: 16'd130, exp: 16'd61},  // R2
        '{num: 12'd384,  den: 12'd1625, n: 16'd200, exp: 16'd47},  // R2
        '{num: 12'd256,  den: 12'd1125, n: 16'd300, exp: 16'd68},  // R2
        '{num: 12'd4,    den: 12'd25,   n: 16'd24,  exp: 16'd3},   // R2 remainder dropped
        '{num: 12'd0,    den: 12'd25,   n: 16'd50,  exp: 16'd0},   // R2 zero numerator
        '{num: 12'd3,    den: 12'd0,    n: 16'd40,  exp: 16'd40},  // R8 zero denominator
        '{num: 12'd30,   den: 12'd25,   n: 16'd20,  exp: 16'd20},  // R9 ratio above one
        '{num: 12'd4095, den: 12'd4095, n: 16'd10,  exp: 16'd10}   // R9 ratio equal one
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [7:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic [CW-1:0] count_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ratio_tick_counter #(
        .COUNT_W   (CW),
        .NUM_HI_RST(NHI),
        .DEN_HI_RST(DHI)
    ) i_ratio_tick_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data),
        .count_o(count_o)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(logic [7:0] a, logic [31:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_read(logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0]   rd;
        logic [CW-1:0] c0;
        logic [CW-1:0] dl;

        // R1 reset state
        run(3);
        check("R1 count in reset", 32'(count_o), 32'd0);
        reg_read(A_NUM, rd);
        check("R1 numerator reset", rd, {NHI, 12'd4});
        reg_read(A_DEN, rd);
        check("R1 denominator reset", rd, {DHI, 12'd25});
        rst_n = 1'b1;
        c0 = count_o;
        run(100);
        dl = count_o - c0;
        check("R1 default ratio 4/25 over 100 clocks", 32'(dl), 32'd16);

        // R11 unmapped read
        reg_read(8'h18, rd);
        check("R11 unmapped read", rd, 32'd0);

        // table of ratios: R2 R8 R9, with R4 readback
        for (int i = 0; i < NV; i++) begin
            reg_write(A_NUM, {20'hFFFFF, VECS[i].num});
            reg_write(A_DEN, {20'hABCDE, VECS[i].den});
            reg_read(A_NUM, rd);
            check($sformatf("R4 numerator readback vec %0d", i), rd, {NHI, VECS[i].num});
            reg_read(A_DEN, rd);
            check($sformatf("R4 denominator readback vec %0d", i), rd, {DHI, VECS[i].den});
            c0 = count_o;
            run(int'(VECS[i].n));
            dl = count_o - c0;
            check($sformatf("R2/R8/R9 count delta vec %0d", i), 32'(dl), 32'(VECS[i].exp));
        end

        // R5 writes elsewhere leave both registers alone
        reg_write(A_NUM, 32'd7);
        reg_write(A_DEN, 32'd50);
        reg_write(8'h18, 32'h0000_0ABC);
        reg_write(8'h11, 32'h0000_0123);
        reg_write(8'h00, 32'h0000_0FFF);
        reg_read(A_NUM, rd);
        check("R5 numerator untouched", rd, {NHI, 12'd7});
        reg_read(A_DEN, rd);
        check("R5 denominator untouched", rd, {DHI, 12'd50});

        // R6 numerator write used from the following clock
        reg_write(A_NUM, 32'd4);
        reg_write(A_DEN, 32'd25);
        c0 = count_o;
        reg_write(A_NUM, 32'd20);
        run(3);
        dl = count_o - c0;
        check("R6 numerator change timing", 32'(dl), 32'd2);

        // R7 denominator write restarts remainder, no count on that clock
        reg_write(A_NUM, 32'd4);
        reg_write(A_DEN, 32'd25);
        run(6);
        c0 = count_o;
        reg_write(A_DEN, 32'd25);
        dl = count_o - c0;
        check("R7 no count on denominator write", 32'(dl), 32'd0);
        run(6);
        dl = count_o - c0;
        check("R7 remainder restarted", 32'(dl), 32'd0);
        run(1);
        dl = count_o - c0;
        check("R7 first count after restart", 32'(dl), 32'd1);

        // R3 single steps at full rate, then R10 wrap
        reg_write(A_NUM, 32'd1);
        reg_write(A_DEN, 32'd1);
        c0 = count_o;
        run(1);
        dl = count_o - c0;
        check("R3 one step per clock", 32'(dl), 32'd1);
        c0 = count_o;
        run(4096 - int'(c0) - 1);
        check("R10 count at all ones", 32'(count_o), 32'hFFF);
        run(1);
        check("R10 wrap to zero", 32'(count_o), 32'd0);
        run(1);
        check("R10 continues after wrap", 32'(count_o), 32'd1);

        finish_run();
    end
endmodule